// File: doc/BRIEF.md
# PCI Configuration Access Bridge

This block gives a host processor a way into PCI configuration space. The processor first writes a 32-bit selection word. That word arrives byte-reversed. After the swap it names a bus, a device, a function and a register. The processor then issues reads and writes on a data port. Each access is 8, 16 or 32 bits wide and carries a byte offset.

When device 0 is selected, the access is served from a 256-byte register file that belongs to the bridge itself. Multi-byte values are packed big-endian. Any other device number is forwarded on a simple request/ready interface, which carries a reduced register index, the size and the offset. Such a request is held until the target answers. While a forwarded request is pending, new data-port requests are not accepted.

A model-select input, sampled during reset, picks one of two sets of reset contents. Three sticky flags report problems:
- a misaligned internal access;
- an illegal size code;
- a direct byte write that asks for little-endian mode, which the bridge does not support.

Top module: `pci_cfg_bridge`

## Requirements
- R1: A write on the address port is byte-swapped before decoding (swapped word = {a[7:0],a[15:8],a[23:16],a[31:24]}). The device comes from swapped bits 15:11 and the register from bits 7:0. The bus (bits 23:16) and the function (bits 10:8) have no effect on where an access goes.
- R2: With device 0 selected, a data access targets internal byte index (register + offset) modulo 256, and nothing is forwarded.
- R3: Internal accesses use big-endian lanes; an 8-bit access uses bits 7:0. A 16-bit access maps byte i to bits 15:8 and byte i+1 to bits 7:0. A 32-bit access maps bytes i..i+3 to bits 31:24 down to 7:0. Size code 0 means 8 bits, 1 means 16 bits and 2 means 32 bits.
- R4: With a nonzero device, the bridge raises a downstream request carrying the device, the register index ((register >> 2) & 0x3C), the size, the offset, the direction and the write data. All of these are held until ready is seen.
- R5: A forwarded access completes one cycle after the downstream ready. A read returns the downstream read data on the response.
- R6: An internal access gives a response pulse one cycle after the request. A read returns its data with that pulse, and a write returns zero.
- R7: Reset stores the identification halfwords 0x1057 (vendor) and 0x0001 or 0x0002 (device) at bytes 0x00..0x03, little-endian. It also loads the common words at 0x04, 0x08, 0xA8, 0xAC, 0xB8, 0xF0, 0xF4 and 0xFC, little-endian (for example 0x04 holds 0x00800006), and clears all other bytes.
- R8: The second model (model_sel = 1) has device ID 0x0002 and adds words at 0x0C (0x00000800), 0x70 (0x00CD0000), 0xC0, 0xE0 and 0xE8. Any model_sel other than 1 gives the first model.
- R9: Reset clears the selection to device 0, register 0, and clears all flags and outputs.
- R10: A direct byte write to index 0xA8 with bit 5 set raises the sticky endian flag. The byte is still stored, and lane order is unchanged.
- R11: An internal 16-bit access with an odd offset, or an internal 32-bit access with a nonzero offset, sets the sticky misalign flag. The access still completes.
- R12: Size code 3 is illegal. It returns a response with zero data and sets the sticky size flag. It writes nothing and forwards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| model_sel | input | 2 | Model choice sampled during reset (1 = second model) |
| addr_wr | input | 1 | Write strobe for the selection word |
| addr_data | input | 32 | Byte-reversed selection word |
| req_valid | input | 1 | Data-port access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = illegal |
| req_offset | input | 2 | Byte offset added to the register |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Access completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| reg_wr | input | 1 | Direct byte write strobe into the register file |
| reg_addr | input | 8 | Direct write byte index |
| reg_wdata | input | 8 | Direct write byte |
| ds_req | output | 1 | Downstream request, held until ds_ready |
| ds_write | output | 1 | Downstream direction |
| ds_dev | output | 5 | Downstream device number |
| ds_reg | output | 8 | Downstream register index |
| ds_size | output | 2 | Downstream size code |
| ds_offset | output | 2 | Downstream byte offset |
| ds_wdata | output | 32 | Downstream write data |
| ds_ready | input | 1 | Downstream completion strobe |
| ds_rdata | input | 32 | Downstream read data, valid with ds_ready |
| misalign_err | output | 1 | Sticky misaligned internal access flag |
| size_err | output | 1 | Sticky illegal size flag |
| endian_err | output | 1 | Sticky little-endian request flag |

## Verification
A wrong register-file byte stays invisible until a data-port read covers its index. At that point it appears in the lane it should occupy, in the response pulse one cycle later. Reset-content and endian-packing faults are therefore exposed by 32-bit reads of the loaded words, where a reversed or shifted lane changes a known value.

A wrong latched device or register shows up either as a forward where an internal response was due, or as a wrong ds_dev or ds_reg. This appears in the first cycle after the request.

Flag faults show as a flag that rises at the wrong time or falls again. They appear on the cycle after the offending access.

// File: rtl/pci_cfg_bridge.sv
module pci_cfg_bridge #(
  parameter int NBYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  model_sel,
  input  logic        addr_wr,
  input  logic [31:0] addr_data,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [1:0]  req_offset,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic        ds_req,
  output logic        ds_write,
  output logic [4:0]  ds_dev,
  output logic [7:0]  ds_reg,
  output logic [1:0]  ds_size,
  output logic [1:0]  ds_offset,
  output logic [31:0] ds_wdata,
  input  logic        ds_ready,
  input  logic [31:0] ds_rdata,
  output logic        misalign_err,
  output logic        size_err,
  output logic        endian_err
);
  localparam logic [7:0] ENDIAN_IDX = 8'hA8;
  localparam int         ENDIAN_BIT = 5;

  logic [7:0] regs [NBYTES];
  logic [4:0] sel_dev;
  logic [7:0] sel_reg;

  wire [31:0] sw = {addr_data[7:0], addr_data[15:8], addr_data[23:16], addr_data[31:24]};
  wire unused_addr_bits = ^{sw[31:16], sw[10:8]};
  wire model_b = (model_sel == 2'd1);

  wire [7:0] i0 = sel_reg + {6'b0, req_offset};
  wire [7:0] i1 = i0 + 8'd1;
  wire [7:0] i2 = i0 + 8'd2;
  wire [7:0] i3 = i0 + 8'd3;

  logic [31:0] int_rd;
  always_comb begin
    case (req_size)
      2'd0:    int_rd = {24'b0, regs[i0]};
      2'd1:    int_rd = {16'b0, regs[i0], regs[i1]};
      2'd2:    int_rd = {regs[i0], regs[i1], regs[i2], regs[i3]};
      default: int_rd = '0;
    endcase
  end

  wire accept   = req_valid && !ds_req;
  wire bad_size = (req_size == 2'd3);
  wire internal = (sel_dev == 5'd0);
  wire misalign = (req_size == 2'd1 && req_offset[0]) || (req_size == 2'd2 && req_offset != 2'd0);

  function automatic logic [7:0] rst_byte(input logic mb, input logic [7:0] a);
    logic [31:0] w;
    case (a[7:2])
      6'h00:   w = mb ? 32'h0002_1057 : 32'h0001_1057;
      6'h01:   w = 32'h0080_0006;
      6'h02:   w = 32'h0006_0000;
      6'h03:   w = mb ? 32'h0000_0800 : 32'h0;
      6'h1C:   w = mb ? 32'h00CD_0000 : 32'h0;
      6'h2A:   w = 32'h0010_FF00;
      6'h2B:   w = 32'h060C_000C;
      6'h2E:   w = 32'h0400_0000;
      6'h30:   w = mb ? 32'h0000_0100 : 32'h0;
      6'h38:   w = mb ? 32'h0042_0FFF : 32'h0;
      6'h3A:   w = mb ? 32'h0020_0000 : 32'h0;
      6'h3C:   w = 32'h0000_FF02;
      6'h3D:   w = 32'h0003_0000;
      6'h3F:   w = 32'h0000_0010;
      default: w = 32'h0;
    endcase
    return w[8*a[1:0] +: 8];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NBYTES; k++) regs[k] <= rst_byte(model_b, 8'(k));
      sel_dev      <= '0;
      sel_reg      <= '0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      ds_req       <= 1'b0;
      ds_write     <= 1'b0;
      ds_dev       <= '0;
      ds_reg       <= '0;
      ds_size      <= '0;
      ds_offset    <= '0;
      ds_wdata     <= '0;
      misalign_err <= 1'b0;
      size_err     <= 1'b0;
      endian_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (addr_wr) begin
        sel_dev <= sw[15:11];
        sel_reg <= sw[7:0];
      end
      if (accept) begin
        if (bad_size) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
          size_err  <= 1'b1;
        end else if (internal) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= req_write ? 32'h0 : int_rd;
          if (misalign) misalign_err <= 1'b1;
          if (req_write) begin
            case (req_size)
              2'd0: regs[i0] <= req_wdata[7:0];
              2'd1: begin
                regs[i0] <= req_wdata[15:8];
                regs[i1] <= req_wdata[7:0];
              end
              default: begin
                regs[i0] <= req_wdata[31:24];
                regs[i1] <= req_wdata[23:16];
                regs[i2] <= req_wdata[15:8];
                regs[i3] <= req_wdata[7:0];
              end
            endcase
          end
        end else begin
          ds_req    <= 1'b1;
          ds_write  <= req_write;
          ds_dev    <= sel_dev;
          ds_reg    <= {2'b0, sel_reg[7:4], 2'b0};
          ds_size   <= req_size;
          ds_offset <= req_offset;
          ds_wdata  <= req_wdata;
        end
      end
      if (ds_req && ds_ready) begin
        ds_req    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_rdata <= ds_write ? 32'h0 : ds_rdata;
      end
      if (reg_wr) begin
        regs[reg_addr] <= reg_wdata;
        if (reg_addr == ENDIAN_IDX && reg_wdata[ENDIAN_BIT]) endian_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pci_cfg_bridge_chk.sv
module pci_cfg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_size,
  input logic        rsp_valid,
  input logic        ds_req,
  input logic        ds_ready,
  input logic        ds_write,
  input logic [4:0]  ds_dev,
  input logic [7:0]  ds_reg,
  input logic [31:0] ds_wdata,
  input logic        misalign_err,
  input logic        size_err,
  input logic        endian_err
);
  // R4
  ds_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req && !ds_ready |=> ds_req && $stable(ds_dev) && $stable(ds_reg) && $stable(ds_wdata) && $stable(ds_write));
  // R4
  ds_dev_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req |-> ds_dev != 5'd0);
  // R4
  ds_reg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req |-> (ds_reg[1:0] == 2'b00 && ds_reg[7:6] == 2'b00));
  // R5
  ds_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req && ds_ready |=> !ds_req && rsp_valid);
  // R5
  no_rsp_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ds_req && rsp_valid));
  // R11
  misalign_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |=> misalign_err);
  // R12
  size_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |=> size_err);
  // R12
  size_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'd3 && !ds_req |=> !ds_req && rsp_valid);
  // R10
  endian_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    endian_err |=> endian_err);
endmodule

bind pci_cfg_bridge pci_cfg_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .rsp_valid(rsp_valid), .ds_req(ds_req), .ds_ready(ds_ready), .ds_write(ds_write),
  .ds_dev(ds_dev), .ds_reg(ds_reg), .ds_wdata(ds_wdata),
  .misalign_err(misalign_err), .size_err(size_err), .endian_err(endian_err)
);

// File: tb/tb_pci_cfg_bridge.sv
`timescale 1ns/1ps
module tb_pci_cfg_bridge;
  logic clk = 0, rst_n = 0;
  logic [1:0] model_sel = 0;
  logic addr_wr = 0; logic [31:0] addr_data = 0;
  logic req_valid = 0, req_write = 0; logic [1:0] req_size = 0, req_offset = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid; logic [31:0] rsp_rdata;
  logic reg_wr = 0; logic [7:0] reg_addr = 0, reg_wdata = 0;
  logic ds_req, ds_write; logic [4:0] ds_dev; logic [7:0] ds_reg;
  logic [1:0] ds_size, ds_offset; logic [31:0] ds_wdata;
  logic ds_ready = 0; logic [31:0] ds_rdata = 0;
  logic misalign_err, size_err, endian_err;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  pci_cfg_bridge dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] swap32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk); model_sel = m; rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic set_addr(input logic [7:0] bus, input logic [4:0] dev, input logic [2:0] fn, input logic [7:0] rg);
    @(negedge clk); addr_wr = 1; addr_data = swap32({8'h00, bus, dev, fn, rg});
    @(negedge clk); addr_wr = 0;
  endtask

  task automatic int_acc(input string req, input logic wr, input logic [1:0] sz, input logic [1:0] off,
                         input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk); req_valid = 1; req_write = wr; req_size = sz; req_offset = off; req_wdata = wd;
    @(negedge clk); req_valid = 0;
    chk({req, " R6 rsp one cycle after request"}, 32'(rsp_valid), 32'd1);
    chk({req, " R2 not forwarded"}, 32'(ds_req), 32'd0);
    rd = rsp_rdata;
    @(negedge clk);
    chk({req, " R6 single pulse"}, 32'(rsp_valid), 32'd0);
  endtask

  task automatic rd32(input string req, input logic [7:0] rg, input logic [31:0] exp);
    logic [31:0] r;
    set_addr(8'h00, 5'd0, 3'd0, rg);
    int_acc(req, 1'b0, 2'd2, 2'd0, 32'h0, r);
    chk(req, r, exp);
  endtask

  task automatic t_reset_first;
    logic [31:0] r;
    do_reset(2'd0);
    chk("R9 flags clear", {29'b0, misalign_err, size_err, endian_err}, 32'h0);
    chk("R9 outputs idle", {30'b0, ds_req, rsp_valid}, 32'h0);
    int_acc("R9 default selection dev0 reg0", 1'b0, 2'd2, 2'd0, 32'h0, r);
    chk("R7 id bytes first model", r, 32'h5710_0100);
    rd32("R7 word 0x04", 8'h04, 32'h0600_8000);
    rd32("R7 word 0xFC", 8'hFC, 32'h1000_0000);
    rd32("R8 first model lacks 0x0C", 8'h0C, 32'h0);
    rd32("R7 word 0xAC", 8'hAC, 32'h0C00_0C06);
  endtask

  task automatic t_reset_second;
    do_reset(2'd1);
    rd32("R8 id second model", 8'h00, 32'h5710_0200);
    rd32("R8 word 0x0C", 8'h0C, 32'h0008_0000);
    rd32("R8 word 0x70", 8'h70, 32'h0000_CD00);
    rd32("R8 word 0xE0", 8'hE0, 32'hFF0F_4200);
  endtask

  task automatic t_model_fallback;
    do_reset(2'd3);
    rd32("R8 fallback id", 8'h00, 32'h5710_0100);
    rd32("R8 fallback no 0x70", 8'h70, 32'h0);
  endtask

  task automatic t_lanes;
    logic [31:0] r;
    do_reset(2'd0);
    set_addr(8'h05, 5'd0, 3'd6, 8'h40);
    int_acc("R3 write32", 1'b1, 2'd2, 2'd0, 32'hA1B2_C3D4, r);
    chk("R6 write returns zero", r, 32'h0);
    int_acc("R3 read8", 1'b0, 2'd0, 2'd0, 32'h0, r);
    chk("R3 byte0 high lane", r, 32'h0000_00A1);
    int_acc("R3 read8", 1'b0, 2'd0, 2'd3, 32'h0, r);
    chk("R2 offset 3 byte", r, 32'h0000_00D4);
    int_acc("R3 read16", 1'b0, 2'd1, 2'd2, 32'h0, r);
    chk("R3 16-bit packing", r, 32'h0000_C3D4);
    int_acc("R3 write16", 1'b1, 2'd1, 2'd2, 32'h0000_1234, r);
    int_acc("R3 read32", 1'b0, 2'd2, 2'd0, 32'h0, r);
    chk("R3 16-bit write lanes, R1 bus/fn ignored", r, 32'hA1B2_1234);
    chk("R11 aligned accesses no flag", 32'(misalign_err), 32'd0);
  endtask

  task automatic t_wrap;
    logic [31:0] r;
    do_reset(2'd0);
    set_addr(8'h00, 5'd0, 3'd0, 8'hFE);
    int_acc("R2 wrap write", 1'b1, 2'd2, 2'd0, 32'h1122_3344, r);
    rd32("R2 index wraps modulo 256", 8'h00, 32'h3344_0100);
    rd32("R2 top bytes", 8'hFC, 32'h1000_1122);
  endtask

  task automatic t_misalign;
    logic [31:0] r;
    do_reset(2'd0);
    set_addr(8'h00, 5'd0, 3'd0, 8'h04);
    int_acc("R11 odd 16-bit", 1'b0, 2'd1, 2'd1, 32'h0, r);
    chk("R11 access completes", r, 32'h0000_0080);
    chk("R11 flag set", 32'(misalign_err), 32'd1);
    int_acc("R11 aligned after", 1'b0, 2'd0, 2'd0, 32'h0, r);
    chk("R11 flag sticky", 32'(misalign_err), 32'd1);
    do_reset(2'd0);
    set_addr(8'h00, 5'd0, 3'd0, 8'h04);
    int_acc("R11 32-bit offset 2", 1'b0, 2'd2, 2'd2, 32'h0, r);
    chk("R11 32-bit misalign data", r, 32'h8000_0000);
    chk("R11 32-bit misalign flag", 32'(misalign_err), 32'd1);
  endtask

  task automatic t_size;
    logic [31:0] r;
    do_reset(2'd0);
    set_addr(8'h00, 5'd0, 3'd0, 8'h04);
    int_acc("R12 illegal write", 1'b1, 2'd3, 2'd0, 32'hDEAD_BEEF, r);
    chk("R12 zero data", r, 32'h0);
    chk("R12 flag", 32'(size_err), 32'd1);
    rd32("R12 nothing written", 8'h04, 32'h0600_8000);
    set_addr(8'h00, 5'd7, 3'd0, 8'h10);
    int_acc("R12 illegal not forwarded", 1'b0, 2'd3, 2'd0, 32'h0, r);
    chk("R12 forwarded read zero", r, 32'h0);
  endtask

  task automatic t_forward;
    logic [31:0] r;
    do_reset(2'd0);
    set_addr(8'h02, 5'd3, 3'd2, 8'h44);
    @(negedge clk); req_valid = 1; req_write = 0; req_size = 2'd2; req_offset = 2'd0;
    @(negedge clk); req_valid = 0;
    chk("R4 request raised", 32'(ds_req), 32'd1);
    chk("R4 device", 32'(ds_dev), 32'd3);
    chk("R4 register index", 32'(ds_reg), 32'h10);
    chk("R4 size/dir", {29'b0, ds_size, ds_write}, {29'b0, 2'd2, 1'b0});
    chk("R5 no early response", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R4 held without ready", {31'b0, ds_req}, 32'd1);
    ds_ready = 1; ds_rdata = 32'hCAFE_F00D;
    @(negedge clk); ds_ready = 0;
    chk("R5 completes after ready", {30'b0, ds_req, rsp_valid}, 32'h1);
    chk("R5 read data", rsp_rdata, 32'hCAFE_F00D);
    set_addr(8'h00, 5'd31, 3'd0, 8'hFF);
    @(negedge clk); req_valid = 1; req_write = 1; req_size = 2'd0; req_offset = 2'd2; req_wdata = 32'h5A;
    @(negedge clk); req_valid = 0;
    chk("R4 write fields", {ds_wdata[7:0], 3'b0, ds_dev, ds_reg, 5'b0, ds_write, ds_offset},
        {8'h5A, 3'b0, 5'd31, 8'h3C, 5'b0, 1'b1, 2'd2});
    ds_ready = 1;
    @(negedge clk); ds_ready = 0;
    chk("R5 write completes", {rsp_valid, rsp_rdata[30:0]}, 32'h8000_0000);
    rd32("R2 forward left file intact", 8'hFC, 32'h1000_0000);
  endtask

  task automatic t_endian;
    logic [31:0] r;
    do_reset(2'd0);
    @(negedge clk); reg_wr = 1; reg_addr = 8'hA8; reg_wdata = 8'h1F;
    @(negedge clk); reg_wr = 0;
    chk("R10 bit5 clear no flag", 32'(endian_err), 32'd0);
    @(negedge clk); reg_wr = 1; reg_addr = 8'hA8; reg_wdata = 8'h20;
    @(negedge clk); reg_wr = 0;
    chk("R10 flag raised", 32'(endian_err), 32'd1);
    set_addr(8'h00, 5'd0, 3'd0, 8'hA8);
    int_acc("R10 read16", 1'b0, 2'd1, 2'd0, 32'h0, r);
    chk("R10 byte stored, lanes unchanged", r, 32'h0000_20FF);
  endtask

  initial begin
    t_reset_first;
    t_reset_second;
    t_model_fallback;
    t_lanes;
    t_wrap;
    t_misalign;
    t_size;
    t_forward;
    t_endian;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule